// File: doc/BRIEF.md
# Interrupt Pin to Target Router

This block sits between a bank of interrupt request pins and the fabric that carries interrupt messages to processor targets. Each pin has a routing entry, supplied by a separate register block, that holds a mask bit, a vector, a delivery mode, a physical or logical destination mode, a polarity and a trigger bit, and an 8-bit destination. When a pin goes from low to high and its entry is unmasked, the pin is marked pending. Pending pins are served one at a time, lowest pin number first. Each one becomes a single message that names its receivers as a bitmask over the targets.

Receivers are chosen in one of two ways. In physical mode the destination is a target index, and the all-ones value addresses every target. In logical mode every target supplies its own 8-bit group value, and a target is chosen when that value shares a set bit with the destination. Lowest-priority delivery narrows a logical match to a single target. It does not compare priorities. A rotation counter, taken modulo the number of matches, picks the target, counting from the lowest index. Lowest-priority delivery in physical mode is not supported: the block raises an error pulse instead of sending. In external-interrupt delivery mode the vector comes from the legacy controller input and not from the entry.

The sequencer has three states. In IDLE, a non-empty pending set latches the lowest pending pin and moves to EVAL. In EVAL, the entry is evaluated: a configuration error or an empty target set returns to IDLE, and anything else loads the message and moves to SEND. In SEND, the message stays presented until `msg_ready`, and then the sequencer returns to IDLE. The pending flag of the served pin is cleared in EVAL.

Top module: `irq_router`

## Requirements
- R1: A pin is acted on only when its sampled level goes from 0 to 1. Holding it high produces no further message. Dropping it to 0 and raising it again produces a new message.
- R2: A pin whose entry mask bit is 1 when it rises produces no message.
- R3: A message carries the entry vector, the delivery mode (3 bits), the destination mode (1 = logical), a level bit equal to the entry polarity, and the entry trigger bit.
- R4: With delivery mode 3'b111 (external), the message vector equals `ext_vector` and not the entry vector.
- R5: In physical mode, destination 8'hFF sets every bit of `msg_targets`. A destination below the target count sets only that index. A higher destination selects nothing, and no message is sent.
- R6: Delivery mode 3'b001 (lowest priority) with physical destination mode sends no message and pulses `cfg_error` high for exactly one cycle.
- R7: In logical mode, target t is selected when its 8-bit group value ANDed with the destination is non-zero.
- R8: For lowest-priority delivery in logical mode with at least one match, exactly one target is sent: the match at position (counter mod match count) in ascending index order. The counter then increments by one.
- R9: Pins that are pending together are served lowest index first, one message each. While `msg_valid` is 1 and `msg_ready` is 0, the message is held unchanged.
- R10: A delivery whose target set is empty is dropped, and the rotation counter does not advance.
- R11: After reset, `msg_valid` and `cfg_error` are 0, and no pin is tracked high, pending, or counted in the rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NUM_PINS | Interrupt request levels |
| ent_mask | input | NUM_PINS | Per-pin mask bit |
| ent_vector | input | NUM_PINS*VEC_W | Per-pin vector, pin p at [p*VEC_W +: VEC_W] |
| ent_mode | input | NUM_PINS*3 | Per-pin delivery mode |
| ent_logical | input | NUM_PINS | Per-pin destination mode, 1 = logical |
| ent_polarity | input | NUM_PINS | Per-pin polarity, copied to the level bit |
| ent_trigger | input | NUM_PINS | Per-pin trigger mode |
| ent_dest | input | NUM_PINS*DEST_W | Per-pin destination |
| tgt_group | input | NUM_TGT*DEST_W | Per-target logical group value |
| ext_vector | input | VEC_W | Vector from the legacy controller |
| msg_valid | output | 1 | Message presented |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_targets | output | NUM_TGT | Receiver bitmask |
| msg_vector | output | VEC_W | Message vector |
| msg_mode | output | 3 | Delivery mode |
| msg_logical | output | 1 | Destination mode |
| msg_level | output | 1 | Level bit |
| msg_trigger | output | 1 | Trigger bit |
| cfg_error | output | 1 | Pulse on an unsupported lowest-priority physical request |

## Verification
The hardest state to reach from the ports is a rotation counter with a known non-zero value and a multi-member match set, together with proof that a dropped empty-match request did not move the counter. The bench raises and lowers one lowest-priority pin four times against a three-target group. It then sends a lowest-priority request that matches no target, and raises the first pin again to check that the pick continues from the expected position. A second case holds `msg_ready` low while three pins rise in the same cycle. This forces a backlog of pending pins and a stalled message at the same time.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVAL,
        ST_SEND
    } rtr_state_e;

    localparam logic [2:0] DLV_FIXED    = 3'b000;
    localparam logic [2:0] DLV_LOWEST   = 3'b001;
    localparam logic [2:0] DLV_EXTERNAL = 3'b111;
endpackage

// File: rtl/irq_edge_pending.sv
module irq_edge_pending #(
    parameter int NUM_PINS = 24,
    localparam int PIN_W = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] allow,
    input  logic [NUM_PINS-1:0] clr,
    output logic                any_pending,
    output logic [PIN_W-1:0]    first_pending
);
    logic [NUM_PINS-1:0] pin_q;
    logic [NUM_PINS-1:0] pending_q;
    logic [NUM_PINS-1:0] rise;

    assign rise = pin_in & ~pin_q & allow;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q     <= '0;
            pending_q <= '0;
        end else begin
            pin_q     <= pin_in;
            pending_q <= (pending_q & ~clr) | rise;
        end
    end

    assign any_pending = |pending_q;

    // lowest index wins: scan downward so the last hit is the lowest
    always_comb begin
        first_pending = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (pending_q[i]) first_pending = PIN_W'(i);
        end
    end
endmodule

// File: rtl/irq_target_select.sv
module irq_target_select
    import irq_router_pkg::*;
#(
    parameter int NUM_TGT = 8,
    parameter int DEST_W  = 8,
    parameter int ROT_W   = 8
) (
    input  logic [DEST_W-1:0]         dest,
    input  logic                      logical,
    input  logic [2:0]                mode,
    input  logic [NUM_TGT*DEST_W-1:0] tgt_group,
    input  logic [ROT_W-1:0]          rot,
    output logic [NUM_TGT-1:0]        targets,
    output logic                      lp_phys_err,
    output logic                      lp_pick
);
    localparam logic [DEST_W-1:0] BCAST = '1;

    logic [NUM_TGT-1:0] phys_set;
    logic [NUM_TGT-1:0] grp_set;
    logic [NUM_TGT-1:0] one_set;
    logic [ROT_W-1:0]   match_cnt;
    logic [ROT_W-1:0]   pick_idx;
    logic [ROT_W-1:0]   run;
    logic               is_lp;

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        assign grp_set[t]  = |(tgt_group[t*DEST_W +: DEST_W] & dest);
        assign phys_set[t] = (dest == BCAST) || (dest == DEST_W'(t));
    end

    always_comb begin
        match_cnt = '0;
        for (int t = 0; t < NUM_TGT; t++) begin
            match_cnt = match_cnt + ROT_W'(grp_set[t]);
        end
    end

    assign pick_idx = (match_cnt == '0) ? '0 : (rot % match_cnt);

    // walk the matched set in ascending index order to the picked slot
    always_comb begin
        one_set = '0;
        run     = '0;
        for (int t = 0; t < NUM_TGT; t++) begin
            if (grp_set[t]) begin
                if (run == pick_idx) one_set[t] = 1'b1;
                run = run + 1'b1;
            end
        end
    end

    assign is_lp       = (mode == DLV_LOWEST);
    assign lp_phys_err = is_lp && !logical;
    assign lp_pick     = is_lp && logical;

    always_comb begin
        if (!logical) targets = is_lp ? '0 : phys_set;
        else          targets = is_lp ? one_set : grp_set;
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int NUM_TGT  = 8,
    parameter int DEST_W   = 8,
    parameter int VEC_W    = 8,
    parameter int ROT_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PINS-1:0]        pin_in,
    input  logic [NUM_PINS-1:0]        ent_mask,
    input  logic [NUM_PINS*VEC_W-1:0]  ent_vector,
    input  logic [NUM_PINS*3-1:0]      ent_mode,
    input  logic [NUM_PINS-1:0]        ent_logical,
    input  logic [NUM_PINS-1:0]        ent_polarity,
    input  logic [NUM_PINS-1:0]        ent_trigger,
    input  logic [NUM_PINS*DEST_W-1:0] ent_dest,
    input  logic [NUM_TGT*DEST_W-1:0]  tgt_group,
    input  logic [VEC_W-1:0]           ext_vector,
    output logic                       msg_valid,
    input  logic                       msg_ready,
    output logic [NUM_TGT-1:0]         msg_targets,
    output logic [VEC_W-1:0]           msg_vector,
    output logic [2:0]                 msg_mode,
    output logic                       msg_logical,
    output logic                       msg_level,
    output logic                       msg_trigger,
    output logic                       cfg_error
);
    localparam int PIN_W = $clog2(NUM_PINS);

    rtr_state_e          state_q, state_d;
    logic [PIN_W-1:0]    sel_q;
    logic [ROT_W-1:0]    rot_q;
    logic                any_pending;
    logic [PIN_W-1:0]    first_pending;
    logic [NUM_PINS-1:0] clr;

    logic [VEC_W-1:0]    sel_vector;
    logic [2:0]          sel_mode;
    logic [DEST_W-1:0]   sel_dest;
    logic                sel_logical;
    logic                sel_polarity;
    logic                sel_trigger;
    logic [NUM_TGT-1:0]  targets;
    logic                lp_phys_err;
    logic                lp_pick;
    logic                deliver;

    irq_edge_pending #(.NUM_PINS(NUM_PINS)) u_edge (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_in        (pin_in),
        .allow         (~ent_mask),
        .clr           (clr),
        .any_pending   (any_pending),
        .first_pending (first_pending)
    );

    assign sel_vector   = ent_vector[int'(sel_q)*VEC_W +: VEC_W];
    assign sel_mode     = ent_mode[int'(sel_q)*3 +: 3];
    assign sel_dest     = ent_dest[int'(sel_q)*DEST_W +: DEST_W];
    assign sel_logical  = ent_logical[sel_q];
    assign sel_polarity = ent_polarity[sel_q];
    assign sel_trigger  = ent_trigger[sel_q];

    irq_target_select #(
        .NUM_TGT (NUM_TGT),
        .DEST_W  (DEST_W),
        .ROT_W   (ROT_W)
    ) u_sel (
        .dest        (sel_dest),
        .logical     (sel_logical),
        .mode        (sel_mode),
        .tgt_group   (tgt_group),
        .rot         (rot_q),
        .targets     (targets),
        .lp_phys_err (lp_phys_err),
        .lp_pick     (lp_pick)
    );

    assign deliver = !lp_phys_err && (targets != '0);
    assign clr     = (state_q == ST_EVAL) ? (NUM_PINS'(1) << sel_q) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (any_pending) state_d = ST_EVAL;
            ST_EVAL: state_d = deliver ? ST_SEND : ST_IDLE;
            ST_SEND: if (msg_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q       <= '0;
            rot_q       <= '0;
            msg_valid   <= 1'b0;
            msg_targets <= '0;
            msg_vector  <= '0;
            msg_mode    <= DLV_FIXED;
            msg_logical <= 1'b0;
            msg_level   <= 1'b0;
            msg_trigger <= 1'b0;
            cfg_error   <= 1'b0;
        end else begin
            cfg_error <= (state_q == ST_EVAL) && lp_phys_err;
            unique case (state_q)
                ST_IDLE: if (any_pending) sel_q <= first_pending;
                ST_EVAL: if (deliver) begin
                    msg_valid   <= 1'b1;
                    msg_targets <= targets;
                    msg_vector  <= (sel_mode == DLV_EXTERNAL) ? ext_vector : sel_vector;
                    msg_mode    <= sel_mode;
                    msg_logical <= sel_logical;
                    msg_level   <= sel_polarity;
                    msg_trigger <= sel_trigger;
                    if (lp_pick) rot_q <= rot_q + 1'b1;
                end
                ST_SEND: if (msg_ready) msg_valid <= 1'b0;
                default: msg_valid <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int NUM_TGT = 8,
    parameter int VEC_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [NUM_TGT-1:0] msg_targets,
    input logic [VEC_W-1:0]   msg_vector,
    input logic [2:0]         msg_mode,
    input logic               msg_logical,
    input logic               cfg_error
);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_targets)
            && $stable(msg_vector) && $stable(msg_mode));

    assert_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_targets != '0);

    assert_single_pick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_mode == DLV_LOWEST |-> $countones(msg_targets) == 1);

    assert_phys_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_logical |-> ($countones(msg_targets) == 1) || (&msg_targets));

    assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |-> !msg_valid);

    assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |=> !cfg_error);

    assert_lp_logical_R6: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_mode == DLV_LOWEST |-> msg_logical);
endmodule

bind irq_router irq_router_chk #(.NUM_TGT(NUM_TGT), .VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .msg_valid   (msg_valid),
    .msg_ready   (msg_ready),
    .msg_targets (msg_targets),
    .msg_vector  (msg_vector),
    .msg_mode    (msg_mode),
    .msg_logical (msg_logical),
    .cfg_error   (cfg_error)
);

// File: tb/irq_router_tb.sv
`timescale 1ns/1ps
module irq_router_tb;
    localparam int NP = 24;
    localparam int NT = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic [NP-1:0] ent_mask = '1;
    logic [NP*8-1:0] ent_vector = '0;
    logic [NP*3-1:0] ent_mode = '0;
    logic [NP-1:0] ent_logical = '0;
    logic [NP-1:0] ent_polarity = '0;
    logic [NP-1:0] ent_trigger = '0;
    logic [NP*8-1:0] ent_dest = '0;
    logic [NT*8-1:0] tgt_group = '0;
    logic [7:0]    ext_vector = 8'h33;
    logic          rdy = 1'b1;

    logic          msg_valid;
    logic [NT-1:0] msg_targets;
    logic [7:0]    msg_vector;
    logic [2:0]    msg_mode;
    logic          msg_logical, msg_level, msg_trigger, cfg_error;

    int checks = 0;
    int fails  = 0;

    logic [NT-1:0] c_tgt;
    logic [7:0]    c_vec;
    logic [2:0]    c_mode;
    logic          c_log, c_lvl, c_trg;

    always #2.5 clk = ~clk;

    irq_router u_dut (
        .clk (clk), .rst_n (rst_n), .pin_in (pins), .ent_mask (ent_mask),
        .ent_vector (ent_vector), .ent_mode (ent_mode), .ent_logical (ent_logical),
        .ent_polarity (ent_polarity), .ent_trigger (ent_trigger), .ent_dest (ent_dest),
        .tgt_group (tgt_group), .ext_vector (ext_vector), .msg_valid (msg_valid),
        .msg_ready (rdy), .msg_targets (msg_targets), .msg_vector (msg_vector),
        .msg_mode (msg_mode), .msg_logical (msg_logical), .msg_level (msg_level),
        .msg_trigger (msg_trigger), .cfg_error (cfg_error)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_entry(input int p, input logic m, input logic [7:0] v,
                             input logic [2:0] md, input logic lg, input logic pol,
                             input logic trg, input logic [7:0] d);
        ent_mask[p]        = m;
        ent_vector[p*8 +: 8] = v;
        ent_mode[p*3 +: 3] = md;
        ent_logical[p]     = lg;
        ent_polarity[p]    = pol;
        ent_trigger[p]     = trg;
        ent_dest[p*8 +: 8] = d;
    endtask

    task automatic wait_msg(output bit got);
        got = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (msg_valid) begin
                c_tgt = msg_targets; c_vec = msg_vector; c_mode = msg_mode;
                c_log = msg_logical; c_lvl = msg_level; c_trg = msg_trigger;
                got = 1;
                return;
            end
        end
    endtask

    task automatic watch(input int n, output int nmsg, output int nerr);
        nmsg = 0; nerr = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (msg_valid) nmsg++;
            if (cfg_error) nerr++;
        end
    endtask

    task automatic raise(input int p);
        @(negedge clk); pins[p] = 1'b1;
    endtask

    task automatic lower(input int p);
        @(negedge clk); pins[p] = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 valid after reset", 32'(msg_valid), 0);
        chk("R11 error after reset", 32'(cfg_error), 0);
    endtask

    task automatic t_edge();
        bit got; int nm, ne;
        set_entry(3, 0, 8'h41, 3'b000, 0, 0, 0, 8'd2);
        raise(3); wait_msg(got);
        chk("R1 first rise delivers", 32'(got), 1);
        chk("R5 physical index 2", 32'(c_tgt), 32'h04);
        chk("R3 vector", 32'(c_vec), 32'h41);
        chk("R3 level low", 32'(c_lvl), 0);
        watch(12, nm, ne);
        chk("R1 held high no repeat", 32'(nm), 0);
        lower(3); raise(3); wait_msg(got);
        chk("R1 second rise delivers", 32'(got), 1);
        lower(3);
    endtask

    task automatic t_mask();
        int nm, ne;
        set_entry(5, 1, 8'h50, 3'b000, 0, 0, 0, 8'd1);
        raise(5); watch(12, nm, ne);
        chk("R2 masked pin silent", 32'(nm), 0);
        lower(5);
    endtask

    task automatic t_fields();
        bit got;
        set_entry(7, 0, 8'h9A, 3'b000, 0, 1, 1, 8'hFF);
        raise(7); wait_msg(got);
        chk("R5 broadcast", 32'(c_tgt), 32'hFF);
        chk("R3 vector", 32'(c_vec), 32'h9A);
        chk("R3 level from polarity", 32'(c_lvl), 1);
        chk("R3 trigger", 32'(c_trg), 1);
        chk("R3 mode and dest mode", {28'd0, c_mode, c_log}, 32'h0);
        lower(7);
    endtask

    task automatic t_extint();
        bit got;
        set_entry(8, 0, 8'h55, 3'b111, 0, 0, 0, 8'd1);
        raise(8); wait_msg(got);
        chk("R4 external vector", 32'(c_vec), 32'h33);
        chk("R4 mode copied", 32'(c_mode), 32'h7);
        lower(8);
    endtask

    task automatic t_phys_range();
        int nm, ne;
        set_entry(10, 0, 8'h60, 3'b000, 0, 0, 0, 8'h20);
        raise(10); watch(12, nm, ne);
        chk("R5 out-of-range dest dropped", 32'(nm), 0);
        lower(10);
    endtask

    task automatic t_lp_phys();
        int nm, ne;
        set_entry(9, 0, 8'h70, 3'b001, 0, 0, 0, 8'd1);
        raise(9); watch(12, nm, ne);
        chk("R6 no message", 32'(nm), 0);
        chk("R6 one error pulse", 32'(ne), 1);
        lower(9);
    endtask

    task automatic t_logical();
        bit got;
        set_entry(4, 0, 8'h44, 3'b000, 1, 0, 0, 8'h03);
        raise(4); wait_msg(got);
        chk("R7 group match", 32'(c_tgt), 32'h23);
        chk("R3 logical flag", 32'(c_log), 1);
        lower(4);
    endtask

    task automatic t_lowest();
        bit got; int nm, ne;
        logic [7:0] expv[4] = '{8'h01, 8'h02, 8'h20, 8'h01};
        set_entry(11, 0, 8'h80, 3'b001, 1, 0, 0, 8'h03);
        for (int k = 0; k < 4; k++) begin
            raise(11); wait_msg(got);
            chk("R8 rotation pick", 32'(c_tgt), 32'(expv[k]));
            lower(11);
        end
        set_entry(12, 0, 8'h81, 3'b001, 1, 0, 0, 8'h00);
        raise(12); watch(12, nm, ne);
        chk("R10 empty match dropped", 32'(nm), 0);
        lower(12);
        raise(11); wait_msg(got);
        chk("R10 counter not advanced", 32'(c_tgt), 32'h02);
        lower(11);
    endtask

    task automatic t_multi();
        bit got;
        set_entry(2, 0, 8'h12, 3'b000, 0, 0, 0, 8'd0);
        set_entry(14, 0, 8'h14, 3'b000, 0, 0, 0, 8'd0);
        set_entry(20, 0, 8'h20, 3'b000, 0, 0, 0, 8'd0);
        @(negedge clk); rdy = 1'b0;
        pins[2] = 1'b1; pins[14] = 1'b1; pins[20] = 1'b1;
        wait_msg(got);
        chk("R9 lowest pin first", 32'(c_vec), 32'h12);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R9 held while stalled", {23'd0, msg_valid, msg_vector}, {23'd0, 1'b1, 8'h12});
        end
        rdy = 1'b1;
        wait_msg(got);
        chk("R9 second pin", 32'(c_vec), 32'h14);
        wait_msg(got);
        chk("R9 third pin", 32'(c_vec), 32'h20);
        @(negedge clk); pins = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int t = 0; t < NT; t++) tgt_group[t*8 +: 8] = 8'h01 << t;
        tgt_group[5*8 +: 8] = 8'h03;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edge();
        t_mask();
        t_fields();
        t_extint();
        t_phys_range();
        t_lp_phys();
        t_logical();
        t_lowest();
        t_multi();
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule